// File: doc/BRIEF.md
# Two-Wire Bus Attach/Detach Detector

This block watches the data and clock lines of a two-wire serial bus and raises an interrupt when the bus is plugged in (attach) or pulled out (detach). Both lines first pass through a synchroniser. A polarity bit chooses which of the two events is armed. An attach event needs only both lines high at the same time. A detach event needs both lines low for a programmable number of clock cycles. A low that ends sooner, as happens during normal bus traffic, is ignored.

Software arms the opposite event after each interrupt by flipping the polarity bit. Any write to the control register restarts the low-time counter and re-arms edge detection. An event whose level condition is already true then fires on the next cycle. A sticky flag records the event and is cleared by writing a 1 to it. The interrupt output is the registered AND of the flag and the enable.

Top module: `bus_link_watch`

## Requirements
- R1: After reset the flag, the enable, the polarity bit, the delay register and `irq_o` are all 0.
- R2: Each bus line passes through a two-flop synchroniser. With polarity 0, enable 1 and no pending flag, `irq_o` rises on the 4th rising edge after both inputs go high.
- R3: With polarity 0, the flag sets when the synchronised lines first become both high. This happens whatever the enable is.
- R4: With polarity 1 and delay D, the flag sets once the synchronised lines have been both low for D+1 consecutive samples. `irq_o` then rises on rising edge D+4 after both inputs go low.
- R5: With polarity 1, a run of both-low samples shorter than D+1 followed by any line high does not set the flag.
- R6: While the level condition persists and the control register is not written, the flag is not set again after it is cleared.
- R7: A write to the control register at address 0 restarts the low-time counter and re-arms detection. A condition that is already true sets the flag in the cycle after the write. The write cycle itself sets nothing.
- R8: The flag is sticky. Writing 1 to bit 0 at address 1 clears it, and writing 0 has no effect. A set and a clear in the same cycle leave the flag set.
- R9: `irq_o` equals the flag ANDed with the enable, delayed by one clock. With the enable at 0 the flag still sets but `irq_o` stays 0.
- R10: The register map is as follows. Address 0 holds bit 0 polarity and bit 1 enable. Address 1 holds bit 0 flag. Address 2 holds the 8-bit delay. Address 3 reads 0. `rdata_o` is loaded on the rising edge where `rd_en_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sda_i | input | 1 | Raw bus data line level |
| scl_i | input | 1 | Raw bus clock line level |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the bus inputs are asynchronous levels that only count once they are synchronised. They also assume that a register write and a read never occur in the same cycle. They further assume that the polarity seen by the event logic changes only through a control write, so a flag that sets without a write in the cycle before must come from the currently armed event. The stimulus changes line levels and strobes only on falling clock edges and issues writes and reads one at a time. It holds each line pattern long enough for the two-stage delay to settle before any cycle count is checked.

// File: rtl/blw_pkg.sv
package blw_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL  = 2'd0,
    RA_FLAG  = 2'd1,
    RA_DELAY = 2'd2,
    RA_NONE  = 2'd3
  } reg_addr_e;

  localparam int CTRL_POL_BIT = 0;
  localparam int CTRL_EN_BIT  = 1;
  localparam int FLAG_BIT     = 0;
endpackage

// File: rtl/blw_sync.sv
module blw_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) begin
        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/blw_low_timer.sv
module blw_low_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             restart_i,
  input  logic             low_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expired_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (restart_i || !low_i) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign expired_o = low_i && (cnt_q >= limit_i);
endmodule

// File: rtl/blw_event.sv
module blw_event (
  input  logic clk_i,
  input  logic rst_i,
  input  logic pol_i,
  input  logic restart_i,
  input  logic both_hi_i,
  input  logic low_qual_i,
  output logic fire_o
);
  logic cond;
  logic seen_q;

  assign cond   = pol_i ? low_qual_i : both_hi_i;
  assign fire_o = cond && !seen_q && !restart_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      seen_q <= 1'b0;
    end else if (restart_i) begin
      seen_q <= 1'b0;
    end else begin
      seen_q <= cond;
    end
  end
endmodule

// File: rtl/blw_regs.sv
module blw_regs
  import blw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DLY_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              fire_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pol_o,
  output logic              en_o,
  output logic [DLY_W-1:0]  delay_o,
  output logic              flag_o,
  output logic              irq_o,
  output logic              ctrl_wr_o,
  output logic              clr_wr_o
);
  logic             pol_q, en_q, flag_q, irq_q;
  logic [DLY_W-1:0] delay_q;
  logic [DATA_W-1:0] rdata_q;

  assign ctrl_wr_o = wr_en_i && (addr_i == RA_CTRL);
  assign clr_wr_o  = wr_en_i && (addr_i == RA_FLAG) && wdata_i[FLAG_BIT];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pol_q   <= 1'b0;
      en_q    <= 1'b0;
      delay_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == RA_CTRL) begin
        pol_q <= wdata_i[CTRL_POL_BIT];
        en_q  <= wdata_i[CTRL_EN_BIT];
      end
      if (addr_i == RA_DELAY) begin
        delay_q <= wdata_i[DLY_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= flag_q && en_q;
      if (fire_i) begin
        flag_q <= 1'b1;
      end else if (clr_wr_o) begin
        flag_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rdata_q <= '0;
    end else if (rd_en_i) begin
      rdata_q <= '0;
      case (addr_i)
        RA_CTRL: begin
          rdata_q[CTRL_POL_BIT] <= pol_q;
          rdata_q[CTRL_EN_BIT]  <= en_q;
        end
        RA_FLAG:  rdata_q[FLAG_BIT] <= flag_q;
        RA_DELAY: rdata_q[DLY_W-1:0] <= delay_q;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;
  assign pol_o   = pol_q;
  assign en_o    = en_q;
  assign delay_o = delay_q;
  assign flag_o  = flag_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/bus_link_watch.sv
module bus_link_watch
  import blw_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DLY_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              sda_i,
  input  logic              scl_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int LINES = 2;

  logic [LINES-1:0] line_s;
  logic             both_hi, both_lo;
  logic             pol, en, flag, ctrl_wr, clr_wr, fire, low_qual;
  logic [DLY_W-1:0] delay, low_cnt;

  blw_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );

  assign both_hi = &line_s;
  assign both_lo = ~|line_s;

  blw_low_timer #(.CNT_W(DLY_W)) u_timer (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .restart_i (ctrl_wr),
    .low_i     (both_lo),
    .limit_i   (delay),
    .cnt_o     (low_cnt),
    .expired_o (low_qual)
  );

  blw_event u_event (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .pol_i      (pol),
    .restart_i  (ctrl_wr),
    .both_hi_i  (both_hi),
    .low_qual_i (low_qual),
    .fire_o     (fire)
  );

  blw_regs #(.DATA_W(DATA_W), .DLY_W(DLY_W)) u_regs (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .fire_i    (fire),
    .rdata_o   (rdata_o),
    .pol_o     (pol),
    .en_o      (en),
    .delay_o   (delay),
    .flag_o    (flag),
    .irq_o     (irq_o),
    .ctrl_wr_o (ctrl_wr),
    .clr_wr_o  (clr_wr)
  );
endmodule

// File: rtl/blw_checker.sv
module blw_checker #(
  parameter int DLY_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             irq,
  input logic             flag,
  input logic             en,
  input logic             pol,
  input logic             ctrl_wr,
  input logic             clr_wr,
  input logic             fire,
  input logic             both_hi,
  input logic             both_lo,
  input logic [DLY_W-1:0] low_cnt,
  input logic [DLY_W-1:0] delay
);
  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(flag) && $past(en)));

  // R7
  no_set_on_ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> !$past(ctrl_wr));

  // R3
  attach_needs_high_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(flag) && !pol && !$past(ctrl_wr)) |-> $past(both_hi));

  // R4
  detach_needs_low_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(flag) && pol && !$past(ctrl_wr)) |-> ($past(both_lo) && ($past(low_cnt) >= $past(delay))));

  // R8
  clear_takes_effect_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !fire) |=> !flag);

  // R8
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> flag);

  // R5
  high_resets_timer_chk: assert property (@(posedge clk) disable iff (rst)
    !both_lo |=> (low_cnt == '0));
endmodule

bind bus_link_watch blw_checker #(.DLY_W(DLY_W)) u_chk (
  .clk     (clk_i),
  .rst     (rst_i),
  .irq     (irq_o),
  .flag    (flag),
  .en      (en),
  .pol     (pol),
  .ctrl_wr (ctrl_wr),
  .clr_wr  (clr_wr),
  .fire    (fire),
  .both_hi (both_hi),
  .both_lo (both_lo),
  .low_cnt (low_cnt),
  .delay   (delay)
);

// File: tb/sim_bus_link_watch.sv
module sim_bus_link_watch;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sda = 1'b0, scl = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  bus_link_watch u0 (
    .clk_i(clk), .rst_i(rst), .sda_i(sda), .scl_i(scl),
    .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model
  bit m_sda1, m_scl1, m_sda2, m_scl2;
  bit m_pol, m_en, m_flag, m_irq, m_prev;
  int m_dly, m_cnt;

  always @(posedge clk) begin : model
    bit pw, cw, blo, bhi, cond, fire;
    if (rst) begin
      {m_sda1, m_scl1, m_sda2, m_scl2} = '0;
      {m_pol, m_en, m_flag, m_irq, m_prev} = '0;
      m_dly = 0; m_cnt = 0;
    end else begin
      pw   = wr && addr == 2'd0;
      cw   = wr && addr == 2'd1 && wdata[0];
      blo  = !m_sda2 && !m_scl2;
      bhi  = m_sda2 && m_scl2;
      cond = m_pol ? (blo && m_cnt >= m_dly) : bhi;
      fire = cond && !m_prev && !pw;
      m_irq = m_flag && m_en;
      if (fire) m_flag = 1'b1;
      else if (cw) m_flag = 1'b0;
      m_prev = pw ? 1'b0 : cond;
      m_cnt  = (pw || !blo) ? 0 : ((m_cnt < 255) ? m_cnt + 1 : 255);
      if (pw) begin m_pol = wdata[0]; m_en = wdata[1]; end
      if (wr && addr == 2'd2) m_dly = wdata;
      m_sda2 = m_sda1; m_scl2 = m_scl1;
      m_sda1 = sda;    m_scl1 = scl;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (irq !== m_irq) begin
        fails++;
        $display("FAIL R9 irq vs model: actual %0b expected %0b at %0t", irq, m_irq, $time);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output int d);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic irq_latency(output int n);
    n = 0;
    while (!irq && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin : main
    int v, lat;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state, R10 map
    check("R1 irq after reset", irq, 0);
    rd_reg(2'd0, v); check("R1 ctrl after reset", v, 0);
    rd_reg(2'd1, v); check("R1 flag after reset", v, 0);
    rd_reg(2'd2, v); check("R1 delay after reset", v, 0);

    // attach event
    wr_reg(2'd0, 8'h02);
    rd_reg(2'd0, v); check("R10 ctrl readback", v, 2);
    sda = 1'b1; scl = 1'b1;
    irq_latency(lat); check("R2 attach irq latency", lat, 4);
    rd_reg(2'd1, v); check("R3 flag after attach", v, 1);

    // sticky, write-one-to-clear, no refire
    wr_reg(2'd1, 8'h00);
    rd_reg(2'd1, v); check("R8 write 0 keeps flag", v, 1);
    wr_reg(2'd1, 8'h01);
    idle(10);
    rd_reg(2'd1, v); check("R6 no refire while high", v, 0);
    check("R6 irq low while high", irq, 0);

    // detach with delay 6, short low first
    wr_reg(2'd2, 8'd6);
    rd_reg(2'd2, v); check("R10 delay readback", v, 6);
    wr_reg(2'd0, 8'h03);
    idle(2);
    sda = 1'b0; scl = 1'b0;
    idle(5);
    sda = 1'b1; scl = 1'b1;
    idle(6);
    rd_reg(2'd1, v); check("R5 short low ignored", v, 0);
    sda = 1'b0; scl = 1'b0;
    irq_latency(lat); check("R4 detach irq latency", lat, 10);
    wr_reg(2'd1, 8'h01);
    idle(20);
    rd_reg(2'd1, v); check("R6 no refire while low", v, 0);

    // restart on control write with level already true
    wr_reg(2'd2, 8'd0);
    wr_reg(2'd0, 8'h03);
    idle(3);
    rd_reg(2'd1, v); check("R7 rearm fires on held low", v, 1);
    wr_reg(2'd1, 8'h01);

    // masked interrupt
    wr_reg(2'd0, 8'h00);
    sda = 1'b1; scl = 1'b1;
    idle(8);
    check("R9 irq masked", irq, 0);
    rd_reg(2'd1, v); check("R9 flag sets while masked", v, 1);
    wr_reg(2'd0, 8'h02);
    idle(2);
    check("R9 irq after enable", irq, 1);

    // set beats clear in the same cycle
    wr_reg(2'd1, 8'h01);
    rd_reg(2'd1, v); check("R8 cleared", v, 0);
    wr_reg(2'd0, 8'h02);
    wr_reg(2'd1, 8'h01);
    rd_reg(2'd1, v); check("R8 set wins over clear", v, 1);

    rd_reg(2'd3, v); check("R10 unused address", v, 0);
    idle(4);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule